// File: doc/BRIEF.md
# Parallel Port Register Block with Timer Pin Overlay

This block holds two 8-bit parallel ports, each with a data register and a direction register, plus the two control registers that steer a pair of external timers. The CPU writes these registers through a small synchronous bus: a 4-bit register select, a write strobe and an 8-bit write bus. It reads them back through a combinational read path. When a port is read, any bit whose direction is input (direction bit 0) reads as 1. Only bits whose direction is output (direction bit 1) show the stored data.

The two upper bits of port B can be handed over to the timers. When a timer's overlay bit is set in its control register, the matching port B bit reads as that timer's output instead of the stored data. The timer's control register selects whether that output is the timer's one-cycle pulse or its toggle level. The block also drives the timers. It passes each control value on as a mode word and issues a one-cycle toggle-reset strobe whenever a write raises a start bit from 0 to 1. It also tells timer B when to count timer A underflows. The counting itself happens outside the block.

Top module: `pio_timer_port`

## Requirements
- R1: After reset every register is zero. Both ports read 0xFF, both direction registers read 0x00, a control register reads only its timer's running state in bit 0, and neither toggle-reset strobe nor the chain request is active.
- R2: Register select 0 is port A data, 1 is port B data, 2 is port A direction and 3 is port B direction. A write stores the byte in the next clock edge. The direction registers read back the stored byte, and the stored data and direction values appear on the port output pins.
- R3: A read of a port returns data OR (NOT direction), so every bit with direction 0 reads as 1.
- R4: When control A (select 14) bit 1 is 1, port B bit 6 reads as the timer A output and not as the port value.
- R5: When control B (select 15) bit 1 is 1, port B bit 7 reads as the timer B output and not as the port value.
- R6: Control bit 2 picks the timer output used by the overlay: 0 selects the timer's pulse input, 1 selects its toggle input.
- R7: A read of a control register returns the stored byte with bits 0 and 4 cleared, and bit 0 replaced by that timer's running input.
- R8: A write that sets control bit 0 while the stored bit 0 is 0 raises that timer's toggle-reset output for exactly the one cycle after the write edge. A write that leaves bit 0 at 1, or clears it, raises nothing.
- R9: The timer A mode output equals control A. The timer B mode output equals control B with bit 5 set whenever bit 6 is set. The chain output is 1 exactly when control B bits 6 and 0 are both 1.
- R10: Selects 4 to 13 read as 0 and writes to them change no register. The read bus is 0 whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 4 | Register select |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| pa_out | output | 8 | Port A stored data |
| pa_oe | output | 8 | Port A direction (1 = output) |
| pb_out | output | 8 | Port B stored data |
| pb_oe | output | 8 | Port B direction (1 = output) |
| ta_pulse | input | 1 | Timer A pulse output |
| ta_level | input | 1 | Timer A toggle output |
| ta_run | input | 1 | Timer A running state |
| tb_pulse | input | 1 | Timer B pulse output |
| tb_level | input | 1 | Timer B toggle output |
| tb_run | input | 1 | Timer B running state |
| ta_mode | output | 8 | Mode word for timer A |
| tb_mode | output | 8 | Mode word for timer B |
| ta_tgl_clr | output | 1 | Timer A toggle reset strobe |
| tb_tgl_clr | output | 1 | Timer B toggle reset strobe |
| tb_chain | output | 1 | Timer B counts timer A underflows |

## Verification
Port reads are tried with a mix of input and output direction bits, so that the OR with the inverted direction is distinguished from a plain data read. The overlay is tried with the pulse and the toggle input set to opposite values under each setting of bit 2, which shows both which input is chosen and that the stored bit is hidden. Start-bit writes are repeated with bit 0 already 1, so that a level-based strobe is told apart from an edge-based one. Control B is written with bit 6 alone, bit 0 alone and both, which shows the chain request and the bit 5 mirror separately.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int NTMR = 2;

  localparam logic [AW-1:0] SEL_PA   = 4'd0;
  localparam logic [AW-1:0] SEL_PB   = 4'd1;
  localparam logic [AW-1:0] SEL_DA   = 4'd2;
  localparam logic [AW-1:0] SEL_DB   = 4'd3;
  localparam logic [AW-1:0] SEL_CTLA = 4'd14;
  localparam logic [AW-1:0] SEL_CTLB = 4'd15;

  localparam int BIT_START   = 0;
  localparam int BIT_OVERLAY = 1;
  localparam int BIT_LEVEL   = 2;
  localparam int BIT_CHAIN   = 6;
  localparam logic [DW-1:0] CTL_VIEW_MASK = 8'hEE;

  function automatic logic [DW-1:0] port_view(input logic [DW-1:0] d, input logic [DW-1:0] dir);
    return d | ~dir;
  endfunction

  function automatic logic [DW-1:0] ctl_view(input logic [DW-1:0] c, input logic run);
    return (c & CTL_VIEW_MASK) | {{(DW-1){1'b0}}, run};
  endfunction

  function automatic logic [DW-1:0] chain_mode(input logic [DW-1:0] c);
    logic [DW-1:0] m;
    m = c;
    m[BIT_CHAIN-1] = c[BIT_CHAIN-1] | c[BIT_CHAIN];
    return m;
  endfunction
endpackage

// File: rtl/pio_regfile.sv
module pio_regfile
  import pio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        sel,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        pa_q,
  output logic [DW-1:0]        pa_dir,
  output logic [DW-1:0]        pb_q,
  output logic [DW-1:0]        pb_dir,
  output logic [NTMR-1:0][DW-1:0] ctl_q,
  output logic [NTMR-1:0]      start_rise
);
  localparam logic [AW-1:0] CTL_SEL [NTMR] = '{SEL_CTLA, SEL_CTLB};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pa_q <= '0; pb_q <= '0; pa_dir <= '0; pb_dir <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_PA: pa_q   <= wdata;
        SEL_PB: pb_q   <= wdata;
        SEL_DA: pa_dir <= wdata;
        SEL_DB: pb_dir <= wdata;
        default: ;
      endcase
    end
  end

  for (genvar t = 0; t < NTMR; t++) begin : g_ctl
    logic hit, rise_ev;
    assign hit     = wr_en && (sel == CTL_SEL[t]);
    assign rise_ev = hit && wdata[BIT_START] && !ctl_q[t][BIT_START];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctl_q[t]      <= '0;
        start_rise[t] <= 1'b0;
      end else begin
        if (hit) ctl_q[t] <= wdata;
        start_rise[t] <= rise_ev;
      end
    end

    AST_STROBE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      start_rise[t] |-> (ctl_q[t][BIT_START] && !$past(ctl_q[t][BIT_START]))); // R8
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_rise[t] |=> !start_rise[t]); // R8
  end

  AST_PA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_PA) |=> (pa_q == $past(wdata))); // R2
  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel > SEL_DB && sel < SEL_CTLA) |=> ($stable(pa_q) && $stable(pb_q) && $stable(pa_dir) && $stable(pb_dir) && $stable(ctl_q))); // R10
endmodule

// File: rtl/pio_timer_link.sv
module pio_timer_link
  import pio_pkg::*;
#(
  parameter bit CHAIN_MIRROR = 1'b0
) (
  input  logic [DW-1:0] ctl,
  input  logic          pulse,
  input  logic          level,
  output logic          overlay_en,
  output logic          pin,
  output logic [DW-1:0] mode,
  output logic          chain
);
  assign overlay_en = ctl[BIT_OVERLAY];
  assign pin        = ctl[BIT_LEVEL] ? level : pulse;

  if (CHAIN_MIRROR) begin : g_mirror
    assign mode  = chain_mode(ctl);
    assign chain = ctl[BIT_CHAIN] & ctl[BIT_START];
  end else begin : g_plain
    assign mode  = ctl;
    assign chain = 1'b0;
  end

  always_comb begin
    if (chain) AST_CHAIN_MIRROR: assert (mode[BIT_CHAIN-1] && mode[BIT_START]); // R9
  end
endmodule

// File: rtl/pio_rdmux.sv
module pio_rdmux
  import pio_pkg::*;
(
  input  logic                 rd_en,
  input  logic [AW-1:0]        sel,
  input  logic [DW-1:0]        pa_q,
  input  logic [DW-1:0]        pa_dir,
  input  logic [DW-1:0]        pb_q,
  input  logic [DW-1:0]        pb_dir,
  input  logic [NTMR-1:0][DW-1:0] ctl_q,
  input  logic [NTMR-1:0]      run,
  input  logic [NTMR-1:0]      ov_en,
  input  logic [NTMR-1:0]      ov_pin,
  output logic [DW-1:0]        rdata
);
  logic [DW-1:0] pb_view;

  always_comb begin
    pb_view = port_view(pb_q, pb_dir);
    for (int t = 0; t < NTMR; t++) begin
      if (ov_en[t]) pb_view[DW-NTMR+t] = ov_pin[t];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (sel)
        SEL_PA:   rdata = port_view(pa_q, pa_dir);
        SEL_PB:   rdata = pb_view;
        SEL_DA:   rdata = pa_dir;
        SEL_DB:   rdata = pb_dir;
        SEL_CTLA: rdata = ctl_view(ctl_q[0], run[0]);
        SEL_CTLB: rdata = ctl_view(ctl_q[1], run[1]);
        default:  rdata = '0;
      endcase
    end
  end

  always_comb begin
    if (rd_en && sel == SEL_PA) AST_INPUT_BITS_HIGH: assert ((~pa_dir & ~rdata) == '0); // R3
    if (rd_en && (sel == SEL_CTLA || sel == SEL_CTLB)) AST_CTL_BIT4_CLEAR: assert (rdata[4] == 1'b0); // R7
    if (!rd_en) AST_IDLE_ZERO: assert (rdata == '0); // R10
  end
endmodule

// File: rtl/pio_timer_port.sv
module pio_timer_port
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    sel,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic [7:0]    pa_out,
  output logic [7:0]    pa_oe,
  output logic [7:0]    pb_out,
  output logic [7:0]    pb_oe,
  input  logic          ta_pulse,
  input  logic          ta_level,
  input  logic          ta_run,
  input  logic          tb_pulse,
  input  logic          tb_level,
  input  logic          tb_run,
  output logic [7:0]    ta_mode,
  output logic [7:0]    tb_mode,
  output logic          ta_tgl_clr,
  output logic          tb_tgl_clr,
  output logic          tb_chain
);
  logic [NTMR-1:0][DW-1:0] ctl_q;
  logic [NTMR-1:0][DW-1:0] mode_w;
  logic [NTMR-1:0]         start_rise, ov_en, ov_pin, chain_w;
  logic [NTMR-1:0]         pulse_w, level_w, run_w;

  assign pulse_w = {tb_pulse, ta_pulse};
  assign level_w = {tb_level, ta_level};
  assign run_w   = {tb_run, ta_run};

  pio_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdata(wdata),
    .pa_q(pa_out), .pa_dir(pa_oe), .pb_q(pb_out), .pb_dir(pb_oe),
    .ctl_q(ctl_q), .start_rise(start_rise)
  );

  for (genvar t = 0; t < NTMR; t++) begin : g_tmr
    pio_timer_link #(.CHAIN_MIRROR(t == 1)) u_link (
      .ctl(ctl_q[t]), .pulse(pulse_w[t]), .level(level_w[t]),
      .overlay_en(ov_en[t]), .pin(ov_pin[t]), .mode(mode_w[t]), .chain(chain_w[t])
    );
  end

  pio_rdmux u_rd (
    .rd_en(rd_en), .sel(sel), .pa_q(pa_out), .pa_dir(pa_oe),
    .pb_q(pb_out), .pb_dir(pb_oe), .ctl_q(ctl_q), .run(run_w),
    .ov_en(ov_en), .ov_pin(ov_pin), .rdata(rdata)
  );

  assign ta_mode    = mode_w[0];
  assign tb_mode    = mode_w[1];
  assign ta_tgl_clr = start_rise[0];
  assign tb_tgl_clr = start_rise[1];
  assign tb_chain   = chain_w[1] | chain_w[0];

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!ta_tgl_clr && !tb_tgl_clr && !tb_chain && pa_oe == '0)); // R1
endmodule

// File: tb/sim_pio_timer_port.sv
module sim_pio_timer_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] sel = '0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, pa_out, pa_oe, pb_out, pb_oe, ta_mode, tb_mode;
  logic ta_pulse = 0, ta_level = 0, ta_run = 0, tb_pulse = 0, tb_level = 0, tb_run = 0;
  logic ta_tgl_clr, tb_tgl_clr, tb_chain;

  int n_checks = 0, n_err = 0;
  bit done = 0;
  logic [7:0] exp_v[$];
  string exp_t[$];

  always #4 clk = ~clk;

  pio_timer_port u0 (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read values and compares at the falling edge
  always @(negedge clk) begin
    if (rd_en) begin
      if (exp_v.size() == 0) chk("unexpected read", rdata, 8'h00);
      else chk(exp_t.pop_front(), rdata, exp_v.pop_front());
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    sel = a; wdata = d; wr_en = 1;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    exp_v.push_back(e); exp_t.push_back(tag);
    sel = a; rd_en = 1;
    @(posedge clk); #1;
    rd_en = 0;
  endtask

  task automatic finish_run;
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++; n_checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 tgl_clr a", {7'b0, ta_tgl_clr}, 8'h00);
    chk("R1 chain", {7'b0, tb_chain}, 8'h00);
    rd(4'd0, 8'hFF, "R1 port A");
    rd(4'd1, 8'hFF, "R1 port B");
    rd(4'd2, 8'h00, "R1 dir A");
    rd(4'd3, 8'h00, "R1 dir B");
    rd(4'd14, 8'h00, "R1 ctl A");
    tb_run = 1;
    rd(4'd15, 8'h01, "R1 ctl B running");
    tb_run = 0;

    // R2 / R3
    wr(4'd0, 8'h5A); wr(4'd2, 8'hF0);
    chk("R2 pa_out", pa_out, 8'h5A);
    chk("R2 pa_oe", pa_oe, 8'hF0);
    rd(4'd2, 8'hF0, "R2 dir A readback");
    rd(4'd0, 8'h5F, "R3 port A mixed");
    wr(4'd1, 8'h7C); wr(4'd3, 8'hFF);
    rd(4'd1, 8'h7C, "R3 port B all out");
    rd(4'd3, 8'hFF, "R2 dir B readback");

    // R4 pulse overlay on bit 6
    wr(4'd14, 8'h02);
    ta_pulse = 1; ta_level = 0;
    rd(4'd1, 8'h7C, "R4 overlay pulse=1");
    ta_pulse = 0;
    rd(4'd1, 8'h3C, "R4 overlay hides stored bit");
    // R6 toggle select
    wr(4'd14, 8'h06);
    ta_pulse = 1; ta_level = 0;
    rd(4'd1, 8'h3C, "R6 level selected (0)");
    ta_pulse = 0; ta_level = 1;
    rd(4'd1, 8'h7C, "R6 level selected (1)");
    ta_level = 0;
    // R5 timer B on bit 7
    wr(4'd15, 8'h02);
    tb_pulse = 1; tb_level = 0;
    rd(4'd1, 8'hBC, "R5 overlay B pulse=1");
    tb_pulse = 0; tb_level = 1;
    rd(4'd1, 8'h3C, "R5 overlay B pulse=0");
    wr(4'd15, 8'h06);
    rd(4'd1, 8'hBC, "R6 overlay B level=1");
    tb_level = 0;

    // R7 control view
    wr(4'd14, 8'h16);
    rd(4'd14, 8'h06, "R7 ctl A bit4 masked");
    ta_run = 1;
    rd(4'd14, 8'h07, "R7 ctl A running");

    // R8 toggle reset strobe
    wr(4'd14, 8'h17);
    chk("R8 strobe on rise", {7'b0, ta_tgl_clr}, 8'h01);
    @(posedge clk); #1;
    chk("R8 strobe one cycle", {7'b0, ta_tgl_clr}, 8'h00);
    wr(4'd14, 8'h17);
    chk("R8 no strobe when held", {7'b0, ta_tgl_clr}, 8'h00);
    rd(4'd14, 8'h07, "R7 ctl A after start");
    chk("R9 ta_mode raw", ta_mode, 8'h17);
    ta_run = 0;

    // R9 chain + mirror
    wr(4'd15, 8'h41);
    chk("R8 strobe B", {7'b0, tb_tgl_clr}, 8'h01);
    chk("R9 chain on", {7'b0, tb_chain}, 8'h01);
    chk("R9 tb_mode mirror", tb_mode, 8'h61);
    wr(4'd15, 8'h40);
    chk("R9 chain off bit0 low", {7'b0, tb_chain}, 8'h00);
    chk("R9 tb_mode bit6 only", tb_mode, 8'h60);
    chk("R8 no strobe on clear", {7'b0, tb_tgl_clr}, 8'h00);
    wr(4'd15, 8'h01);
    chk("R9 chain off bit6 low", {7'b0, tb_chain}, 8'h00);
    chk("R9 tb_mode bit0 only", tb_mode, 8'h01);

    // R10 unmapped
    for (int a = 4; a < 14; a++) begin
      wr(a[3:0], 8'hAA);
      rd(a[3:0], 8'h00, "R10 unmapped read");
    end
    rd(4'd0, 8'h5F, "R10 port A untouched");
    rd(4'd2, 8'hF0, "R10 dir A untouched");
    rd(4'd14, 8'h06, "R10 ctl A untouched");
    @(posedge clk); #1;
    sel = 4'd0;
    chk("R10 idle bus zero", rdata, 8'h00);

    @(posedge clk); #1;
    if (exp_v.size() != 0) chk("queue drained", 8'(exp_v.size()), 8'h00);
    done = 1;
    finish_run();
  end
endmodule